// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a two-level sum-of-products engine whose AND plane and OR plane are both held in on-chip configuration registers. Software or a boot sequencer loads the personality through a single register-write port: one row per product term in the AND plane, one row per output in the OR plane. Once loaded, the block maps the primary input vector to its outputs through purely combinational logic. A second copy of the outputs is captured in a register on every clock.

Each product term stores a 2-bit code per input. The code picks the input as written, picks it inverted, leaves it out, or kills the whole term. Each output stores one connection bit per product term, which lets one term feed any number of outputs, plus a polarity bit that inverts the OR result. A configuration-lock input freezes the stored matrix.

Top module: `prog_logic_array`

## Requirements
- R1: While and after reset, every AND cell holds 2'b11, every OR connection bit and polarity bit is 0, and both `dataOut` and `regOut` are all zeros for every input vector.
- R2: In an AND-plane row (`wrPlane`=0, `wrRow`=term index), the cell for input i sits at `wrData[2i+1:2i]`. Code 2'b01 requires input i to be 1, code 2'b10 requires it to be 0, and code 2'b00 leaves input i out of the term.
- R3: Any cell holding 2'b11 forces its product term to 0 whatever the inputs are.
- R4: A product term whose cells are all 2'b00 evaluates to 1 for every input vector.
- R5: In an OR-plane row (`wrPlane`=1, `wrRow`=output index), bit t of `wrData` connects product term t to that output. An output with no connected term and polarity 0 is constantly 0.
- R6: Bit `NUM_TERM` of an OR-plane row is the polarity bit for that output. When it is 1, the output is the inverse of the OR of its connected terms.
- R7: One product term connected to several outputs contributes to each of them.
- R8: A write with `wrEn`=1 changes nothing before the next rising clock edge and takes effect from that edge. While `cfgLock` is 1, a write has no effect.
- R9: A write whose row index is at or beyond the row count of the selected plane has no effect.
- R10: `dataOut` follows `dataIn` in the same cycle, and `regOut` equals the `dataOut` value seen at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLock | input | 1 | When high, configuration writes are dropped |
| wrEn | input | 1 | Configuration write strobe |
| wrPlane | input | 1 | 0 selects the AND plane, 1 selects the OR plane |
| wrRow | input | ROW_W | Term index (AND plane) or output index (OR plane) |
| wrData | input | DATA_W | Row contents |
| dataIn | input | NUM_IN | Primary inputs |
| dataOut | output | NUM_OUT | Combinational outputs |
| regOut | output | NUM_OUT | Outputs registered one clock later |

## Verification
The bench targets the degenerate terms and outputs. If a term with no literals were treated as false, an output meant to be stuck high would read 0. If the kill code were decoded as a don't-care, a term meant to be dead would fire on every vector. If an unconnected output defaulted to the polarity of some other row, it would not stay at 0. Writes are aimed at the first row index past each plane's end and are issued while the lock is high: a design that failed to drop them would corrupt a neighbouring row or the shared term set. Every configuration is then swept over all input vectors, so that any change shows up at the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic {
    PLANE_AND = 1'b0,
    PLANE_OR  = 1'b1
  } plane_e;

  // strobes from the write control to the datapath
  typedef struct packed {
    logic andWe;
    logic orWe;
  } wr_strobe_t;

  localparam logic [1:0] CELL_SKIP = 2'b00;
  localparam logic [1:0] CELL_POS  = 2'b01;
  localparam logic [1:0] CELL_NEG  = 2'b10;
  localparam logic [1:0] CELL_KILL = 2'b11;

endpackage

// File: rtl/pla_wr_ctrl.sv
module pla_wr_ctrl
  import pla_pkg::*;
#(
  parameter int NUM_TERM = 16,
  parameter int NUM_OUT  = 8,
  parameter int ROW_W    = 4
) (
  input  logic             wrEn,
  input  logic             cfgLock,
  input  logic             wrPlane,
  input  logic [ROW_W-1:0] wrRow,
  output wr_strobe_t       strobe
);

  localparam logic [ROW_W:0] TERM_LIM = (ROW_W+1)'(NUM_TERM);
  localparam logic [ROW_W:0] OUT_LIM  = (ROW_W+1)'(NUM_OUT);

  logic   writeOk;
  plane_e planeSel;
  logic   termInRange;
  logic   outInRange;

  assign planeSel    = plane_e'(wrPlane);
  assign writeOk     = wrEn && !cfgLock;
  assign termInRange = {1'b0, wrRow} < TERM_LIM;
  assign outInRange  = {1'b0, wrRow} < OUT_LIM;

  always_comb begin
    strobe       = '0;
    strobe.andWe = writeOk && (planeSel == PLANE_AND) && termInRange;
    strobe.orWe  = writeOk && (planeSel == PLANE_OR)  && outInRange;
  end

endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_TERM = 16,
  parameter int NUM_OUT  = 8,
  parameter int ROW_W    = 4,
  parameter int DATA_W   = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  wr_strobe_t         strobe,
  input  logic [ROW_W-1:0]   wrRow,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic [NUM_OUT-1:0] regOut
);

  localparam int CELL_W = 2 * NUM_IN;

  logic [NUM_TERM-1:0][CELL_W-1:0]   andPlane;
  logic [NUM_OUT-1:0][NUM_TERM-1:0]  orPlane;
  logic [NUM_OUT-1:0]                polBits;
  logic [NUM_TERM-1:0][NUM_IN-1:0]   litOk;
  logic [NUM_TERM-1:0]               termHit;

  // personality storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      andPlane <= '1;
      orPlane  <= '0;
      polBits  <= '0;
    end else begin
      for (int t = 0; t < NUM_TERM; t++) begin
        if (strobe.andWe && wrRow == ROW_W'(t)) andPlane[t] <= wrData[CELL_W-1:0];
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (strobe.orWe && wrRow == ROW_W'(o)) begin
          orPlane[o] <= wrData[NUM_TERM-1:0];
          polBits[o] <= wrData[NUM_TERM];
        end
      end
    end
  end

  // AND plane
  for (genvar t = 0; t < NUM_TERM; t++) begin : gTerm
    for (genvar i = 0; i < NUM_IN; i++) begin : gCell
      always_comb begin
        unique case (andPlane[t][2*i +: 2])
          CELL_SKIP: litOk[t][i] = 1'b1;
          CELL_POS:  litOk[t][i] = dataIn[i];
          CELL_NEG:  litOk[t][i] = ~dataIn[i];
          default:   litOk[t][i] = 1'b0;
        endcase
      end

      assert_kill_cell_R3: assert property (@(posedge clk) disable iff (!rstN)
        (andPlane[t][2*i +: 2] == CELL_KILL) |-> !termHit[t]);
    end
    assign termHit[t] = &litOk[t];

    assert_empty_term_true_R4: assert property (@(posedge clk) disable iff (!rstN)
      (andPlane[t] == '0) |-> termHit[t]);
  end

  // OR plane with polarity
  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    assign dataOut[o] = (|(termHit & orPlane[o])) ^ polBits[o];

    assert_empty_output_R5: assert property (@(posedge clk) disable iff (!rstN)
      (orPlane[o] == '0) |-> (dataOut[o] == polBits[o]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) regOut <= '0;
    else       regOut <= dataOut;
  end

  assert_and_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.andWe |=> $stable(andPlane));
  assert_or_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.orWe |=> ($stable(orPlane) && $stable(polBits)));

endmodule

// File: rtl/prog_logic_array.sv
module prog_logic_array
  import pla_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_TERM = 16,
  parameter int NUM_OUT  = 8,
  localparam int MAX_ROW = (NUM_TERM > NUM_OUT) ? NUM_TERM : NUM_OUT,
  localparam int ROW_W   = $clog2((MAX_ROW > 1) ? MAX_ROW : 2),
  localparam int DATA_W  = (2 * NUM_IN > NUM_TERM + 1) ? 2 * NUM_IN : NUM_TERM + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLock,
  input  logic               wrEn,
  input  logic               wrPlane,
  input  logic [ROW_W-1:0]   wrRow,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic [NUM_OUT-1:0] regOut
);

  wr_strobe_t strobe;

  pla_wr_ctrl #(
    .NUM_TERM (NUM_TERM),
    .NUM_OUT  (NUM_OUT),
    .ROW_W    (ROW_W)
  ) uCtrl (
    .wrEn    (wrEn),
    .cfgLock (cfgLock),
    .wrPlane (wrPlane),
    .wrRow   (wrRow),
    .strobe  (strobe)
  );

  pla_datapath #(
    .NUM_IN   (NUM_IN),
    .NUM_TERM (NUM_TERM),
    .NUM_OUT  (NUM_OUT),
    .ROW_W    (ROW_W),
    .DATA_W   (DATA_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrRow   (wrRow),
    .wrData  (wrData),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .regOut  (regOut)
  );

  assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgLock |-> (strobe == '0));
  assert_single_plane_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.andWe, strobe.orWe}));
  assert_term_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.andWe |-> ({1'b0, wrRow} < (ROW_W+1)'(NUM_TERM)));
  assert_out_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.orWe |-> ({1'b0, wrRow} < (ROW_W+1)'(NUM_OUT)));
  assert_reg_copy_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (regOut == $past(dataOut)));

endmodule

// File: tb/tb_prog_logic_array.sv
`timescale 1ns/1ps
module tb_prog_logic_array;

  localparam int NI = 3;
  localparam int NT = 5;
  localparam int NO = 4;
  localparam int RW = 3;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgLock = 1'b0;
  logic          wrEn = 1'b0;
  logic          wrPlane = 1'b0;
  logic [RW-1:0] wrRow = '0;
  logic [DW-1:0] wrData = '0;
  logic [NI-1:0] dataIn = '0;
  logic [NO-1:0] dataOut;
  logic [NO-1:0] regOut;

  int checks = 0;
  int fails  = 0;

  // bench-side shadow of the personality
  logic [1:0] mAnd [NT][NI];
  logic       mOr  [NO][NT];
  logic       mPol [NO];

  always #2.5 clk = ~clk;

  prog_logic_array #(.NUM_IN(NI), .NUM_TERM(NT), .NUM_OUT(NO)) dut (
    .clk(clk), .rstN(rstN), .cfgLock(cfgLock), .wrEn(wrEn), .wrPlane(wrPlane),
    .wrRow(wrRow), .wrData(wrData), .dataIn(dataIn), .dataOut(dataOut), .regOut(regOut)
  );

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) begin
      logic acc = 1'b0;
      for (int t = 0; t < NT; t++) begin
        logic hit = 1'b1;
        for (int i = 0; i < NI; i++) begin
          case (mAnd[t][i])
            2'b00: ;
            2'b01: hit = hit & x[i];
            2'b10: hit = hit & ~x[i];
            default: hit = 1'b0;
          endcase
        end
        acc = acc | (hit & mOr[o][t]);
      end
      r[o] = acc ^ mPol[o];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    logic [NO-1:0] prevExp = '0;
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      if (v > 0) chk("R10 registered copy", regOut, prevExp);
      dataIn = NI'(v);
      #1;
      chk(req, dataOut, model(NI'(v)));
      prevExp = model(NI'(v));
    end
    @(negedge clk);
    chk("R10 registered copy", regOut, prevExp);
  endtask

  // direct formulas for the reference function set, A=in2 B=in1 C=in0
  task automatic refSweep();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      logic [NO-1:0] e;
      {a, b, c} = 3'(v);
      e[0] = a | (~b & ~c);
      e[1] = (a & ~c) | (a & b);
      e[2] = (~b & ~c) | (a & b);
      e[3] = (~b & c) | a;
      @(negedge clk);
      dataIn = 3'(v);
      #1;
      chk("R2 R7 reference functions", dataOut, e);
    end
  endtask

  task automatic doWrite(input logic plane, input int row, input logic [DW-1:0] data,
                         input logic lock);
    @(negedge clk);
    wrEn = 1'b1; wrPlane = plane; wrRow = RW'(row); wrData = data; cfgLock = lock;
    #1;
    chk("R8 no change before edge", dataOut, model(dataIn));
    @(negedge clk);
    wrEn = 1'b0; cfgLock = 1'b0;
    if (!lock) begin
      if (!plane && row < NT)
        for (int i = 0; i < NI; i++) mAnd[row][i] = data[2*i +: 2];
      if (plane && row < NO) begin
        for (int t = 0; t < NT; t++) mOr[row][t] = data[t];
        mPol[row] = data[NT];
      end
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) for (int i = 0; i < NI; i++) mAnd[t][i] = 2'b11;
    for (int o = 0; o < NO; o++) begin
      mPol[o] = 1'b0;
      for (int t = 0; t < NT; t++) mOr[o][t] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset regOut", regOut, '0);
    rstN = 1'b1;
    sweep("R1 reset personality");

    // reference personality: t0=AB t1=B'C t2=AC' t3=B'C' t4=A
    doWrite(1'b0, 0, 6'b01_01_00, 1'b0);
    doWrite(1'b0, 1, 6'b00_10_01, 1'b0);
    doWrite(1'b0, 2, 6'b01_00_10, 1'b0);
    doWrite(1'b0, 3, 6'b00_10_10, 1'b0);
    doWrite(1'b0, 4, 6'b01_00_00, 1'b0);
    sweep("R2 AND rows, OR still empty R5");
    doWrite(1'b1, 0, 6'b0_11000, 1'b0);
    doWrite(1'b1, 1, 6'b0_00101, 1'b0);
    doWrite(1'b1, 2, 6'b0_01001, 1'b0);
    doWrite(1'b1, 3, 6'b0_10010, 1'b0);
    refSweep();
    sweep("R7 shared terms");

    // locked writes dropped
    doWrite(1'b0, 0, 6'b00_00_00, 1'b1);
    doWrite(1'b1, 0, 6'b1_11111, 1'b1);
    sweep("R8 locked write ignored");

    // rows just past each plane's end
    doWrite(1'b0, 5, 6'b00_00_00, 1'b0);
    doWrite(1'b0, 7, 6'b00_00_00, 1'b0);
    doWrite(1'b1, 4, 6'b1_11111, 1'b0);
    sweep("R9 out-of-range row ignored");

    // term with no literals -> constant 1 on F0 and F3
    doWrite(1'b0, 4, 6'b00_00_00, 1'b0);
    sweep("R4 empty term is true");
    chk("R4 F0 F3 stuck high", dataOut & 4'b1001, 4'b1001);

    // kill code in one cell
    doWrite(1'b0, 4, 6'b00_00_11, 1'b0);
    sweep("R3 kill cell forces term low");

    // polarity on F1
    doWrite(1'b1, 1, 6'b1_00101, 1'b0);
    sweep("R6 polarity inverts");

    // F2 disconnected
    doWrite(1'b1, 2, 6'b0_00000, 1'b0);
    sweep("R5 unconnected output is 0");
    chk("R5 F2 low", dataOut & 4'b0100, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule